// File: doc/BRIEF.md
# Register Set Cache Flush Sequencer

This block holds a small cache of local register sets, each of sixteen 32-bit words, together with the stack frame address where each set belongs. On a flush command it writes every valid cached set back to its frame in memory through a single-word write port. It then empties the cache and raises a one-cycle completion pulse. Sets enter the cache through an allocate port that records a frame address, and a load port fills words of the most recently allocated set. The array size is fixed at configuration time, between five and sixteen sets.

With a write port that never stalls, the flush latency is exactly a fixed 14-cycle overhead plus 23 cycles per valid set, so a full cache of five to sixteen sets costs 129 to 382 cycles. The number of cycles spent busy on the most recent flush is kept on an output so that this latency can be checked in place. When to flush is decided outside the block. It is meant to be requested only when the outermost handler exits with a context switch pending, and never on nested exits or exits without a switch.

Top module: `regset_flush_seq`

## Requirements
- R1: After reset, busy, done and mem_wr_valid are 0, valid_sets is 0 and last_cycles is 0.
- R2: An alloc_en pulse while idle with valid_sets below NSETS records alloc_frame as the frame of set index valid_sets and increments valid_sets on the next edge. It is ignored while busy or when valid_sets equals NSETS.
- R3: An ld_en pulse while idle with at least one valid set stores ld_data as word ld_idx of the newest set (index valid_sets-1). It is ignored while busy or when no set is valid.
- R4: A flush_req sampled while idle makes busy high from the next cycle. Busy stays high for exactly 14 + 23*n cycles when mem_wr_ready is held high, where n is valid_sets at acceptance.
- R5: A flush writes the sets in ascending index order, and within a set words 0 to 15 in order. Each write goes to address frame + 4*word, with the data last loaded into that word, and mem_wr_valid is high only while busy.
- R6: A flush accepted with zero valid sets issues no write and stays busy for exactly 14 cycles.
- R7: While mem_wr_valid is high and mem_wr_ready is low, address and data hold steady, and each such stall cycle lengthens the flush by one cycle.
- R8: done is high for exactly one cycle, the cycle right after the last busy cycle. In that cycle valid_sets reads 0 and last_cycles holds the number of busy cycles of that flush.
- R9: A flush_req that arrives while busy is ignored: it neither restarts nor extends the flush in progress.
- R10: With the write port always ready, a flush of 5 sets takes 129 cycles and a flush of 16 sets takes 382 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_en | input | 1 | Add a set to the cache |
| alloc_frame | input | 32 | Frame base address of the added set |
| ld_en | input | 1 | Load one word of the newest set |
| ld_idx | input | 4 | Word index for the load |
| ld_data | input | 32 | Word value for the load |
| flush_req | input | 1 | Start a flush of all valid sets |
| mem_wr_valid | output | 1 | Write port request |
| mem_wr_addr | output | 32 | Write byte address |
| mem_wr_data | output | 32 | Write data |
| mem_wr_ready | input | 1 | Write port accepts the current word |
| busy | output | 1 | Flush in progress |
| done | output | 1 | One-cycle flush completion pulse |
| last_cycles | output | 16 | Busy cycles of the latest flush (saturating) |
| valid_sets | output | 5 | Number of valid cached sets |

## Verification
A wrong phase counter or set index shows within one cycle as a write issued too early, too late or to a wrong address. It also shifts the busy fall and the done pulse, so the cycle-by-cycle comparison catches it at the first divergent cycle, not only in the final latency figure. A corrupted valid count shows up right away on valid_sets, and at the end of the flush as a wrong number of write bursts. Cache contents that are lost or written while locked appear as a data miscompare on the word where they are flushed.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
    localparam int WORD_W        = 32;
    localparam int ADDR_W        = 32;
    localparam int WORDS_PER_SET = 16;
    localparam int OVERHEAD_CYC  = 14;
    localparam int SET_CYC       = 23;
    localparam int GAP_CYC       = SET_CYC - WORDS_PER_SET;
    localparam int WIDX_W        = $clog2(WORDS_PER_SET);
    localparam int PH_W          = $clog2(OVERHEAD_CYC > GAP_CYC ? OVERHEAD_CYC : GAP_CYC);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRE   = 2'd1,
        ST_WRITE = 2'd2,
        ST_GAP   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } wr_beat_t;

    function automatic int flush_cost(input int nsets);
        return OVERHEAD_CYC + SET_CYC * nsets;
    endfunction
endpackage

// File: rtl/rsf_store.sv
module rsf_store
    import rsf_pkg::*;
#(
    parameter int NSETS = 16,
    localparam int SET_W = (NSETS > 1) ? $clog2(NSETS) : 1,
    localparam int CNT_W = $clog2(NSETS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock,
    input  logic              clear,
    input  logic              alloc_en,
    input  logic [ADDR_W-1:0] alloc_frame,
    input  logic              ld_en,
    input  logic [WIDX_W-1:0] ld_idx,
    input  logic [WORD_W-1:0] ld_data,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [WIDX_W-1:0] rd_word,
    output logic [CNT_W-1:0]  count,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [CNT_W-1:0]  count_q;
    logic [ADDR_W-1:0] frame_q [NSETS];
    logic [WORD_W-1:0] regs_q  [NSETS][WORDS_PER_SET];

    logic             full;
    logic             do_alloc;
    logic             do_ld;
    logic [SET_W-1:0] new_slot;
    logic [SET_W-1:0] top_slot;

    always_comb begin
        full     = (count_q == CNT_W'(NSETS));
        do_alloc = alloc_en && !lock && !full;
        do_ld    = ld_en && !lock && (count_q != '0);
        new_slot = SET_W'(count_q);
        top_slot = SET_W'(count_q - CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (do_alloc) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_alloc) begin
            frame_q[new_slot] <= alloc_frame;
        end
        if (do_ld) begin
            regs_q[top_slot][ld_idx] <= ld_data;
        end
    end

    always_comb begin
        count   = count_q;
        rd_addr = frame_q[rd_set] + (ADDR_W'(rd_word) << 2);
        rd_data = regs_q[rd_set][rd_word];
    end
endmodule

// File: rtl/rsf_seq.sv
module rsf_seq
    import rsf_pkg::*;
#(
    parameter int NSETS = 16,
    parameter int CYC_W = 16,
    localparam int SET_W = (NSETS > 1) ? $clog2(NSETS) : 1,
    localparam int CNT_W = $clog2(NSETS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush_req,
    input  logic [CNT_W-1:0]  set_count,
    input  logic              mem_ready,
    output logic              busy,
    output logic              done,
    output logic              finish,
    output logic              wr_valid,
    output logic [SET_W-1:0]  rd_set,
    output logic [WIDX_W-1:0] rd_word,
    output logic [CYC_W-1:0]  last_cycles
);
    localparam logic [PH_W-1:0]   PRE_LAST  = PH_W'(OVERHEAD_CYC - 1);
    localparam logic [PH_W-1:0]   GAP_LAST  = PH_W'(GAP_CYC - 1);
    localparam logic [WIDX_W-1:0] WORD_LAST = WIDX_W'(WORDS_PER_SET - 1);

    seq_state_e        state_q;
    logic [PH_W-1:0]   ph_q;
    logic [SET_W-1:0]  sidx_q;
    logic [WIDX_W-1:0] widx_q;
    logic [CYC_W-1:0]  cyc_q;
    logic [CYC_W-1:0]  cyc_next;
    logic [CYC_W-1:0]  last_q;
    logic              done_q;
    logic              last_set;

    always_comb begin
        cyc_next = (cyc_q == '1) ? cyc_q : cyc_q + CYC_W'(1);
        last_set = (CNT_W'(sidx_q) == set_count - CNT_W'(1));
        finish   = ((state_q == ST_PRE) && (ph_q == PRE_LAST) && (set_count == '0)) ||
                   ((state_q == ST_GAP) && (ph_q == GAP_LAST) && last_set);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ph_q    <= '0;
            sidx_q  <= '0;
            widx_q  <= '0;
            cyc_q   <= '0;
            last_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q != ST_IDLE) begin
                cyc_q <= cyc_next;
            end
            if (finish) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
                last_q  <= cyc_next;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (flush_req) begin
                            state_q <= ST_PRE;
                            ph_q    <= '0;
                            sidx_q  <= '0;
                            widx_q  <= '0;
                            cyc_q   <= '0;
                        end
                    end
                    ST_PRE: begin
                        if (ph_q == PRE_LAST) begin
                            state_q <= ST_WRITE;
                        end else begin
                            ph_q <= ph_q + PH_W'(1);
                        end
                    end
                    ST_WRITE: begin
                        if (mem_ready) begin
                            if (widx_q == WORD_LAST) begin
                                state_q <= ST_GAP;
                                ph_q    <= '0;
                                widx_q  <= '0;
                            end else begin
                                widx_q <= widx_q + WIDX_W'(1);
                            end
                        end
                    end
                    ST_GAP: begin
                        if (ph_q == GAP_LAST) begin
                            sidx_q  <= sidx_q + SET_W'(1);
                            state_q <= ST_WRITE;
                        end else begin
                            ph_q <= ph_q + PH_W'(1);
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        busy        = (state_q != ST_IDLE);
        wr_valid    = (state_q == ST_WRITE);
        done        = done_q;
        rd_set      = sidx_q;
        rd_word     = widx_q;
        last_cycles = last_q;
    end
endmodule

// File: rtl/regset_flush_seq.sv
module regset_flush_seq
    import rsf_pkg::*;
#(
    parameter int NSETS = 16,
    parameter int CYC_W = 16,
    localparam int SET_W = (NSETS > 1) ? $clog2(NSETS) : 1,
    localparam int CNT_W = $clog2(NSETS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_en,
    input  logic [ADDR_W-1:0] alloc_frame,
    input  logic              ld_en,
    input  logic [WIDX_W-1:0] ld_idx,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              flush_req,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [WORD_W-1:0] mem_wr_data,
    input  logic              mem_wr_ready,
    output logic              busy,
    output logic              done,
    output logic [CYC_W-1:0]  last_cycles,
    output logic [CNT_W-1:0]  valid_sets
);
    logic              seq_busy;
    logic              seq_finish;
    logic [SET_W-1:0]  rd_set;
    logic [WIDX_W-1:0] rd_word;
    logic [CNT_W-1:0]  count;
    wr_beat_t          beat;

    rsf_seq #(.NSETS(NSETS), .CYC_W(CYC_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .flush_req  (flush_req),
        .set_count  (count),
        .mem_ready  (mem_wr_ready),
        .busy       (seq_busy),
        .done       (done),
        .finish     (seq_finish),
        .wr_valid   (beat.valid),
        .rd_set     (rd_set),
        .rd_word    (rd_word),
        .last_cycles(last_cycles)
    );

    rsf_store #(.NSETS(NSETS)) u_store (
        .clk        (clk),
        .rst        (rst),
        .lock       (seq_busy),
        .clear      (seq_finish),
        .alloc_en   (alloc_en),
        .alloc_frame(alloc_frame),
        .ld_en      (ld_en),
        .ld_idx     (ld_idx),
        .ld_data    (ld_data),
        .rd_set     (rd_set),
        .rd_word    (rd_word),
        .count      (count),
        .rd_addr    (beat.addr),
        .rd_data    (beat.data)
    );

    always_comb begin
        busy         = seq_busy;
        valid_sets   = count;
        mem_wr_valid = beat.valid;
        mem_wr_addr  = beat.addr;
        mem_wr_data  = beat.data;
    end
endmodule

// File: rtl/rsf_chk.sv
module rsf_chk
    import rsf_pkg::*;
#(
    parameter int NSETS = 16,
    parameter int CYC_W = 16,
    localparam int CNT_W = $clog2(NSETS + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              flush_req,
    input logic              mem_wr_valid,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [WORD_W-1:0] mem_wr_data,
    input logic              mem_wr_ready,
    input logic              busy,
    input logic              done,
    input logic [CNT_W-1:0]  valid_sets
);
    // R8: completion pulse lasts a single cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: completion comes with an idle sequencer and an empty cache
    a_r8_done_empty: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && valid_sets == '0));

    // R8: every end of a busy stretch is announced
    a_r8_fall_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R5: writes only happen during a flush
    a_r5_write_busy: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid |-> busy);

    // R7: a stalled write holds address and data
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    // R4: a flush only starts from a sampled request
    a_r4_start_req: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(flush_req));

    // R2: the cache never holds more than its capacity
    a_r2_cap: assert property (@(posedge clk) disable iff (rst)
        valid_sets <= CNT_W'(NSETS));

    // R2: the valid count is frozen while a flush runs
    a_r2_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(valid_sets)));
endmodule

bind regset_flush_seq rsf_chk #(.NSETS(NSETS), .CYC_W(CYC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .flush_req   (flush_req),
    .mem_wr_valid(mem_wr_valid),
    .mem_wr_addr (mem_wr_addr),
    .mem_wr_data (mem_wr_data),
    .mem_wr_ready(mem_wr_ready),
    .busy        (busy),
    .done        (done),
    .valid_sets  (valid_sets)
);

// File: tb/regset_flush_seq_tb.sv
module regset_flush_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alloc_en = 1'b0;
    logic [31:0] alloc_frame = '0;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_idx = '0;
    logic [31:0] ld_data = '0;
    logic        flush_req = 1'b0;
    logic        mem_wr_ready = 1'b1;
    logic        mem_wr_valid;
    logic [31:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic        busy;
    logic        done;
    logic [15:0] last_cycles;
    logic [4:0]  valid_sets;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    int stall_mode = 0;

    // reference model state
    int          m_sets = 0;
    logic [31:0] m_frame [16];
    logic [31:0] m_data  [16][16];
    logic [64:0] plan [$];
    bit          m_busy = 0;
    bit          m_done = 0;
    int          m_cyc  = 0;
    int          m_last = 0;

    always #4 clk = ~clk;

    regset_flush_seq u_dut (
        .clk(clk), .rst(rst), .alloc_en(alloc_en), .alloc_frame(alloc_frame),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data), .flush_req(flush_req),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_ready(mem_wr_ready), .busy(busy), .done(done),
        .last_cycles(last_cycles), .valid_sets(valid_sets)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model advanced on each rising edge
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_sets = 0; m_busy = 0; m_done = 0; m_cyc = 0; m_last = 0;
            plan.delete();
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cyc++;
                if (!plan[0][64] || mem_wr_ready) void'(plan.pop_front());
                if (plan.size() == 0) begin
                    m_busy = 0; m_done = 1; m_last = m_cyc; m_sets = 0;
                end
            end else begin
                if (flush_req) begin
                    for (int i = 0; i < 14; i++) plan.push_back('0);
                    for (int s = 0; s < m_sets; s++) begin
                        for (int w = 0; w < 16; w++)
                            plan.push_back({1'b1, m_frame[s] + 32'(4 * w), m_data[s][w]});
                        for (int g = 0; g < 7; g++) plan.push_back('0);
                    end
                    m_busy = 1; m_cyc = 0;
                end
                if (ld_en && m_sets > 0) m_data[m_sets-1][ld_idx] = ld_data;
                if (alloc_en && m_sets < 16) begin
                    m_frame[m_sets] = alloc_frame;
                    m_sets++;
                end
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check(busy == m_busy, "R4 busy", busy, m_busy);
            check(done == m_done, "R8 done", done, m_done);
            check(valid_sets == 5'(m_sets), "R2 valid_sets", valid_sets, m_sets);
            check(last_cycles == 16'(m_last), "R8 last_cycles", last_cycles, m_last);
            if (m_busy && plan.size() > 0 && plan[0][64]) begin
                check(mem_wr_valid == 1'b1, "R5 write valid", mem_wr_valid, 1);
                check(mem_wr_addr == plan[0][63:32], "R5 write addr", mem_wr_addr, plan[0][63:32]);
                check(mem_wr_data == plan[0][31:0], "R5 write data", mem_wr_data, plan[0][31:0]);
            end else begin
                check(mem_wr_valid == 1'b0, "R5 no write", mem_wr_valid, 0);
            end
        end
        if (stall_mode != 0) mem_wr_ready = (cycles % 3) != 0;
        else mem_wr_ready = 1'b1;
    end

    task automatic add_set(input logic [31:0] frame, input logic [31:0] seed);
        @(negedge clk); alloc_en = 1; alloc_frame = frame;
        @(negedge clk); alloc_en = 0;
        for (int w = 0; w < 16; w++) begin
            ld_en = 1; ld_idx = 4'(w); ld_data = seed ^ (32'(w) * 32'h0101_0101);
            @(negedge clk);
        end
        ld_en = 0;
    endtask

    task automatic pulse_flush();
        @(negedge clk); flush_req = 1;
        @(negedge clk); flush_req = 0;
    endtask

    task automatic wait_done();
        while (!m_done) @(negedge clk);
        check(done == 1'b1, "R8 done seen", done, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 0 && done == 0 && mem_wr_valid == 0, "R1 reset ctrl",
              {busy, done, mem_wr_valid}, 0);
        check(valid_sets == 0 && last_cycles == 0, "R1 reset counters",
              {valid_sets, last_cycles}, 0);
        rst = 0;
        @(negedge clk);

        // R6 empty flush
        pulse_flush(); wait_done();
        check(last_cycles == 14, "R6 empty flush cycles", last_cycles, 14);

        // R4 one set
        add_set(32'h1000_0000, 32'hA5A5_0000);
        pulse_flush(); wait_done();
        check(last_cycles == 37, "R4 one set cycles", last_cycles, 37);

        // R10 five sets, with R9/R2/R3 stimulus while busy
        for (int s = 0; s < 5; s++) add_set(32'h2000_0000 + 32'(s * 'h100), 32'hC0DE_0000 + 32'(s));
        pulse_flush();
        repeat (3) @(negedge clk);
        flush_req = 1; alloc_en = 1; alloc_frame = 32'hDEAD_0000;
        ld_en = 1; ld_idx = 4'd15; ld_data = 32'hBAD0_BAD0;
        @(negedge clk);
        flush_req = 0; alloc_en = 0; ld_en = 0;
        check(valid_sets == 5, "R2 alloc ignored while busy", valid_sets, 5);
        wait_done();
        check(last_cycles == 129, "R10 five sets / R9 no restart / R3 load ignored",
              last_cycles, 129);
        check(valid_sets == 0, "R8 cache empty", valid_sets, 0);

        // R2 capacity, R10 full flush
        for (int s = 0; s < 16; s++) add_set(32'h4000_0000 + 32'(s * 'h40), 32'h5EED_0000 + 32'(s * 7));
        @(negedge clk); alloc_en = 1; alloc_frame = 32'hFFFF_0000;
        @(negedge clk); alloc_en = 0;
        check(valid_sets == 16, "R2 alloc ignored when full", valid_sets, 16);
        pulse_flush(); wait_done();
        check(last_cycles == 382, "R10 sixteen sets cycles", last_cycles, 382);

        // R7 wait states
        add_set(32'h6000_0000, 32'h1234_0000);
        add_set(32'h6000_1000, 32'h4321_0000);
        stall_mode = 1;
        pulse_flush(); wait_done();
        stall_mode = 0;
        check(last_cycles > 60, "R7 stalls lengthen flush", last_cycles, m_last);
        check(last_cycles == 16'(m_last), "R7 stalled cycles", last_cycles, m_last);

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule